// File: doc/BRIEF.md
# EDO DRAM Cycle Decoder with Test Mode

This block is a synthesizable, device-side model of the control logic inside an extended-data-out DRAM. It samples the active-low row strobe, column strobe, write enable and output enable on a fast system clock. From the order in which those strobes move, it decides what kind of memory cycle the external controller is running. A small parameterised cell array stands in for the full capacity. A four-bit data output with a separate enable models the tri-state pins.

When the row strobe falls, the column-strobe and write-enable levels pick the cycle family. With the column strobe high, a normal access cycle begins; it may become a read, an early write, a read-modify-write or a refresh by row strobe alone. With the column strobe low, a refresh cycle begins that uses an internal counter; holding write enable low as well makes it a test-mode entry cycle. In test mode, reads return a pairwise bit-compare result instead of raw data. Two coarse timing rules are watched and reported through a sticky flag: an over-long row-strobe pulse and a too-short column-strobe pulse.

The block is meant as a self-checking target for memory-controller benches: a controller under test drives it, and the decoded cycle kind, refresh row, test-mode flag and violation flag show whether the controller is sequencing the strobes correctly.

Top module: `edo_cycle_decoder`

## Requirements
- R1: After synchronous reset, dout_en=0, dout=0, test_mode=0, rfsh_row=0, viol=0 and cyc_kind=0 (idle).
- R2: In a normal cycle, a column-strobe fall sampled with write enable high is a read. cyc_kind becomes 1, and two clock edges after the fall is sampled, dout holds the cell at {row, column} with dout_en=1 (output enable low).
- R3: A column-strobe fall sampled with write enable already low is an early write. The cell at {row, column} takes din, cyc_kind becomes 2, and dout_en stays 0.
- R4: A write-enable fall while the column strobe is held low in a read cycle is a read-modify-write. The cell takes din, cyc_kind becomes 3, and dout keeps showing the old cell value.
- R5: Several column-strobe pulses may occur within one row-strobe low period (page mode), each accessing its own column. After a read, dout and dout_en stay valid when the column strobe rises, until the next access.
- R6: dout_en falls (and dout becomes 0) two edges after both strobes are sampled high, or one edge after output enable is sampled high.
- R7: A normal cycle whose row strobe rises with no column access is a row-only refresh: cyc_kind becomes 4 and test_mode clears.
- R8: Column strobe low with write enable high at the row-strobe fall is a counter refresh. cyc_kind becomes 5, test_mode clears, and rfsh_row advances by one, modulo 2^RCW.
- R9: Column strobe and write enable both low at the row-strobe fall is a test-entry cycle. cyc_kind becomes 6, test_mode sets, and rfsh_row advances by one.
- R10: While test_mode=1, a read returns dout[i] = dout[i+DW/2] = 1 when cell bit i equals cell bit i+DW/2, and 0 otherwise. Normal reads and writes do not end test mode.
- R11: viol sets when the row strobe has been sampled low for RAS_MAX edges and is still low at the next one; viol stays set until reset.
- R12: viol sets when the column strobe rises after fewer than CAS_MIN low samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Multiplexed row/column address |
| din | input | DW | Write data |
| dout | output | DW | Read data, 0 when not driven |
| dout_en | output | 1 | Output driver enable |
| cyc_kind | output | 3 | Decoded cycle: 0 idle, 1 read, 2 early write, 3 read-modify-write, 4 row-only refresh, 5 counter refresh, 6 test entry |
| test_mode | output | 1 | Test mode active |
| rfsh_row | output | RCW | Next row the refresh counter will use |
| viol | output | 1 | Sticky timing-violation flag |

## Verification
A wrong strobe-order decision is visible on cyc_kind at the edge after the offending strobe transition. It then corrupts later reads, because a misclassified write either leaves a cell untouched or overwrites it. A bad row or column latch shows up as a wrong dout two edges after the next read of any other cell, which the full-array write and readback sweep exposes. A refresh counter that skips or sticks is caught at its first wrong step, because every counter refresh is compared against a running count up to and through the wrap. A test-mode flag stuck in either state shows on the first read, because the compare encoding differs from raw data.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [2:0] {
    K_IDLE   = 3'd0,
    K_READ   = 3'd1,
    K_EWRITE = 3'd2,
    K_RMW    = 3'd3,
    K_RONLY  = 3'd4,
    K_CBR    = 3'd5,
    K_TSET   = 3'd6
  } cyc_kind_e;
endpackage

// File: rtl/edo_cell_array.sv
module edo_cell_array #(
  parameter int DW = 4,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << IW;

  logic [DW-1:0] mem [DEPTH];

  // single clocked read and write, no reset on the array: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    if (re) rdata <= mem[ridx];
  end

  // R4: a read-modify-write never asks for read and write in one edge
  a_r4_port_excl: assert property (@(posedge clk) disable iff (rst) !(we && re));
endmodule

// File: rtl/edo_timing_mon.sv
module edo_timing_mon #(
  parameter int RAS_MAX = 2500,
  parameter int CAS_MIN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic ras_n,
  input  logic cas_n,
  output logic viol
);
  localparam int RCW_W = $clog2(RAS_MAX + 1);
  localparam int CCW_W = $clog2(CAS_MIN + 1);
  localparam logic [RCW_W-1:0] RLIM = RCW_W'(RAS_MAX);
  localparam logic [CCW_W-1:0] CLIM = CCW_W'(CAS_MIN);

  logic [RCW_W-1:0] ras_cnt;
  logic [CCW_W-1:0] cas_cnt;
  logic             cas_q;
  logic             ras_long, cas_short;

  assign ras_long  = !ras_n && (ras_cnt == RLIM);
  assign cas_short = !cas_q && cas_n && (cas_cnt < CLIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_cnt <= '0;
      cas_cnt <= '0;
      cas_q   <= 1'b1;
      viol    <= 1'b0;
    end else begin
      cas_q <= cas_n;
      if (ras_n)                ras_cnt <= '0;
      else if (ras_cnt != RLIM) ras_cnt <= ras_cnt + 1'b1;
      if (cas_n)                cas_cnt <= '0;
      else if (cas_cnt != CLIM) cas_cnt <= cas_cnt + 1'b1;
      if (ras_long || cas_short) viol <= 1'b1;
    end
  end

  // R11: an over-long row strobe raises the flag at the following edge
  a_r11_ras_limit: assert property (@(posedge clk) disable iff (rst)
    (!ras_n && ras_cnt == RLIM) |=> viol);
  // R11 R12: the flag never drops without reset
  a_r12_viol_sticky: assert property (@(posedge clk) disable iff (rst) viol |=> viol);
endmodule

// File: rtl/edo_cycle_fsm.sv
module edo_cycle_fsm
  import edo_pkg::*;
#(
  parameter int AW  = 3,
  parameter int DW  = 4,
  parameter int RCW = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   din,
  output cyc_kind_e       kind,
  output logic            tmode,
  output logic [RCW-1:0]  rrow,
  output logic            rd_live,
  output logic            mem_we,
  output logic [2*AW-1:0] mem_widx,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_re,
  output logic [2*AW-1:0] mem_ridx
);
  logic          ras_q, cas_q, we_q;
  logic          in_norm, saw_cas;
  logic [AW-1:0] row_q, col_q;
  logic          ras_fall, ras_rise, cas_hit, rmw_hit;

  assign ras_fall = ras_q && !ras_n;
  assign ras_rise = !ras_q && ras_n;
  // column access only inside a normal cycle that is already open
  assign cas_hit  = cas_q && !cas_n && !ras_q && !ras_n && in_norm;
  assign rmw_hit  = we_q && !we_n && !cas_q && !cas_n && !ras_n && in_norm
                    && (kind == K_READ);

  assign mem_re    = cas_hit && we_n;
  assign mem_we    = (cas_hit && !we_n) || rmw_hit;
  assign mem_ridx  = {row_q, addr};
  assign mem_widx  = rmw_hit ? {row_q, col_q} : {row_q, addr};
  assign mem_wdata = din;

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_q   <= 1'b1;
      cas_q   <= 1'b1;
      we_q    <= 1'b1;
      in_norm <= 1'b0;
      saw_cas <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
      rd_live <= 1'b0;
      kind    <= K_IDLE;
      tmode   <= 1'b0;
      rrow    <= '0;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      we_q  <= we_n;
      if (ras_fall) begin
        if (cas_n) begin
          in_norm <= 1'b1;
          saw_cas <= 1'b0;
          row_q   <= addr;
        end else begin
          in_norm <= 1'b0;
          rrow    <= rrow + 1'b1;
          if (!we_n) begin
            tmode <= 1'b1;
            kind  <= K_TSET;
          end else begin
            tmode <= 1'b0;
            kind  <= K_CBR;
          end
        end
      end
      if (cas_hit) begin
        saw_cas <= 1'b1;
        col_q   <= addr;
        kind    <= we_n ? K_READ : K_EWRITE;
        rd_live <= we_n;
      end
      if (rmw_hit) kind <= K_RMW;
      if (ras_rise) begin
        in_norm <= 1'b0;
        if (in_norm && !saw_cas) begin
          kind  <= K_RONLY;
          tmode <= 1'b0;
        end
      end
      if (ras_n && cas_n) rd_live <= 1'b0;
    end
  end

  // R9: both low at the row fall always enters test mode
  a_r9_wcbr_enters: assert property (@(posedge clk) disable iff (rst)
    (ras_q && !ras_n && !cas_n && !we_n) |=> tmode);
  // R8: the refresh row only moves on a refresh-type row fall
  a_r8_rrow_hold: assert property (@(posedge clk) disable iff (rst)
    !(ras_q && !ras_n && !cas_n) |=> $stable(rrow));
  // R3: an early write never arms the output
  a_r3_ewrite_quiet: assert property (@(posedge clk) disable iff (rst)
    (cas_hit && !we_n) |=> !rd_live);
  // R7: row-only refresh leaves test mode
  a_r7_ronly_exit: assert property (@(posedge clk) disable iff (rst)
    (ras_rise && in_norm && !saw_cas) |=> (!tmode && kind == K_RONLY));
endmodule

// File: rtl/edo_cycle_decoder.sv
module edo_cycle_decoder
  import edo_pkg::*;
#(
  parameter int AW      = 3,
  parameter int DW      = 4,
  parameter int RCW     = 10,
  parameter int RAS_MAX = 2500,
  parameter int CAS_MIN = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ras_n,
  input  logic           cas_n,
  input  logic           we_n,
  input  logic           oe_n,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  din,
  output logic [DW-1:0]  dout,
  output logic           dout_en,
  output logic [2:0]     cyc_kind,
  output logic           test_mode,
  output logic [RCW-1:0] rfsh_row,
  output logic           viol
);
  localparam int IW   = 2 * AW;
  localparam int HALF = DW / 2;

  cyc_kind_e     kind;
  logic          rd_live, mem_we, mem_re;
  logic [IW-1:0] mem_widx, mem_ridx;
  logic [DW-1:0] mem_wdata, rd_word, cmp_word;

  edo_cycle_fsm #(.AW(AW), .DW(DW), .RCW(RCW)) u_fsm (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .din(din), .kind(kind), .tmode(test_mode), .rrow(rfsh_row),
    .rd_live(rd_live), .mem_we(mem_we), .mem_widx(mem_widx),
    .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_ridx(mem_ridx)
  );

  edo_cell_array #(.DW(DW), .IW(IW)) u_cells (
    .clk(clk), .rst(rst), .we(mem_we), .widx(mem_widx), .wdata(mem_wdata),
    .re(mem_re), .ridx(mem_ridx), .rdata(rd_word)
  );

  edo_timing_mon #(.RAS_MAX(RAS_MAX), .CAS_MIN(CAS_MIN)) u_tmon (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .viol(viol)
  );

  // test-mode compare: lower and upper half bits checked pairwise
  for (genvar i = 0; i < HALF; i++) begin : g_cmp
    assign cmp_word[i]        = (rd_word[i] == rd_word[i+HALF]);
    assign cmp_word[i + HALF] = (rd_word[i] == rd_word[i+HALF]);
  end

  assign cyc_kind = kind;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_en <= 1'b0;
      dout    <= '0;
    end else begin
      dout_en <= rd_live && !oe_n;
      dout    <= (rd_live && !oe_n) ? (test_mode ? cmp_word : rd_word) : '0;
    end
  end

  // R6: output enable high shuts the driver at the next edge
  a_r6_oe_blocks: assert property (@(posedge clk) disable iff (rst) oe_n |=> !dout_en);
  // R6: both strobes high turns the driver off within two edges
  a_r6_precharge_off: assert property (@(posedge clk) disable iff (rst)
    (ras_n && cas_n) |-> ##2 !dout_en);
  // R6: an undriven output reads as zero
  a_r6_zero_when_off: assert property (@(posedge clk) disable iff (rst)
    !dout_en |-> (dout == '0));
endmodule

// File: tb/sim_edo_cycle_decoder.sv
module sim_edo_cycle_decoder;
  localparam int AW = 3, DW = 4, RCW = 10, RAS_MAX = 200, CAS_MIN = 3;
  localparam int N = 1 << AW;

  logic clk = 1'b0;
  logic rst, ras_n, cas_n, we_n, oe_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic dout_en, test_mode, viol;
  logic [2:0] cyc_kind;
  logic [RCW-1:0] rfsh_row;

  int total = 0, bad = 0, exp_row = 0;
  logic [DW-1:0] model [N*N];

  always #2 clk = ~clk;

  edo_cycle_decoder #(.AW(AW), .DW(DW), .RCW(RCW), .RAS_MAX(RAS_MAX), .CAS_MIN(CAS_MIN)) u0 (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .cyc_kind(cyc_kind),
    .test_mode(test_mode), .rfsh_row(rfsh_row), .viol(viol)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] tcmp(logic [DW-1:0] w);
    logic [DW-1:0] r;
    r[0] = (w[0] == w[2]); r[2] = r[0];
    r[1] = (w[1] == w[3]); r[3] = r[1];
    return r;
  endfunction

  task automatic do_reset();
    rst = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b0;
    addr = '0; din = '0;
    step(3);
    rst = 1'b0;
    step(1);
  endtask

  task automatic ras_open(int row);
    addr = AW'(row); ras_n = 1'b0; step(2);
  endtask

  task automatic ras_close();
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; step(3);
  endtask

  task automatic cas_wr(int col, logic [DW-1:0] d);
    addr = AW'(col); we_n = 1'b0; din = d; cas_n = 1'b0;
    step(2);
    check("R3 early write dout_en", int'(dout_en), 0);
    check("R3 early write kind", int'(cyc_kind), 2);
    step(1);
    cas_n = 1'b1; we_n = 1'b1;
    step(1);
  endtask

  task automatic cas_rd(int col, logic [DW-1:0] exp, int kexp);
    addr = AW'(col); we_n = 1'b1; cas_n = 1'b0;
    step(2);
    check("R2 read dout_en", int'(dout_en), 1);
    check("R2 R10 read dout", int'(dout), int'(exp));
    check("R2 read kind", int'(cyc_kind), kexp);
    step(1);
    cas_n = 1'b1;
    step(1);
    check("R5 hold after cas rise en", int'(dout_en), 1);
    check("R5 hold after cas rise data", int'(dout), int'(exp));
  endtask

  task automatic cbr(bit wcbr);
    cas_n = 1'b0; we_n = !wcbr; step(1);
    ras_n = 1'b0; step(3);
    ras_n = 1'b1; step(1);
    cas_n = 1'b1; we_n = 1'b1; step(2);
    exp_row = (exp_row + 1) % (1 << RCW);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 dout_en", int'(dout_en), 0);
    check("R1 dout", int'(dout), 0);
    check("R1 test_mode", int'(test_mode), 0);
    check("R1 rfsh_row", int'(rfsh_row), 0);
    check("R1 viol", int'(viol), 0);
    check("R1 kind", int'(cyc_kind), 0);

    // R3 R5: fill the whole array with page-mode early writes
    for (int r = 0; r < N; r++) begin
      ras_open(r);
      for (int c = 0; c < N; c++) begin
        model[r*N+c] = DW'(r*3 + c*5 + 1);
        cas_wr(c, model[r*N+c]);
      end
      ras_close();
    end
    // R2 R5: page-mode read back of every cell
    for (int r = 0; r < N; r++) begin
      ras_open(r);
      for (int c = N-1; c >= 0; c--) cas_rd(c, model[r*N+c], 1);
      ras_close();
    end

    // R6: output enable gating and precharge turn-off
    ras_open(2);
    oe_n = 1'b1; addr = 3'd1; cas_n = 1'b0; step(2);
    check("R6 oe high en", int'(dout_en), 0);
    check("R6 oe high dout", int'(dout), 0);
    oe_n = 1'b0; step(1);
    check("R6 oe low en", int'(dout_en), 1);
    check("R6 oe low dout", int'(dout), int'(model[2*N+1]));
    cas_n = 1'b1; step(1);
    ras_n = 1'b1; step(1);
    check("R6 one edge after precharge", int'(dout_en), 1);
    step(1);
    check("R6 off after precharge", int'(dout_en), 0);
    check("R6 dout zero", int'(dout), 0);
    step(2);

    // R4: read-modify-write at row 5 col 6
    ras_open(5);
    addr = 3'd6; we_n = 1'b1; cas_n = 1'b0; step(2);
    check("R4 old data before write", int'(dout), int'(model[5*N+6]));
    we_n = 1'b0; din = 4'hA; step(2);
    check("R4 kind", int'(cyc_kind), 3);
    check("R4 old data kept", int'(dout), int'(model[5*N+6]));
    check("R4 still driven", int'(dout_en), 1);
    cas_n = 1'b1; we_n = 1'b1; step(1);
    model[5*N+6] = 4'hA;
    cas_rd(6, model[5*N+6], 1);
    cas_rd(7, model[5*N+7], 1);
    ras_close();

    // R7: row-only refresh
    ras_open(3); step(2); ras_close();
    check("R7 kind", int'(cyc_kind), 4);
    check("R1 R7 counter untouched", int'(rfsh_row), 0);

    // R9: test entry, then R10 compare reads over row 0 and row 5
    cbr(1'b1);
    check("R9 kind", int'(cyc_kind), 6);
    check("R9 test_mode", int'(test_mode), 1);
    check("R9 rfsh_row", int'(rfsh_row), exp_row);
    for (int r = 0; r < N; r += 5) begin
      ras_open(r);
      for (int c = 0; c < N; c++) cas_rd(c, tcmp(model[r*N+c]), 1);
      cas_wr(0, 4'h5);
      model[r*N] = 4'h5;
      cas_rd(0, tcmp(4'h5), 1);
      ras_close();
    end
    check("R10 test mode kept after access", int'(test_mode), 1);
    cbr(1'b1);
    check("R9 test entry repeated", int'(test_mode), 1);
    check("R9 rfsh_row again", int'(rfsh_row), exp_row);
    // R7 ends test mode
    ras_open(1); step(1); ras_close();
    check("R7 exits test mode", int'(test_mode), 0);
    ras_open(0); cas_rd(0, model[0], 1); ras_close();

    // R8: counter refresh exits test mode and walks the counter through its wrap
    cbr(1'b1);
    cbr(1'b0);
    check("R8 exits test mode", int'(test_mode), 0);
    check("R8 kind", int'(cyc_kind), 5);
    for (int k = 0; k < (1 << RCW); k++) begin
      cbr(1'b0);
      check("R8 rfsh_row step", int'(rfsh_row), exp_row);
    end
    check("R11 R12 no false violation", int'(viol), 0);

    // R12: short column strobe
    do_reset();
    ras_open(0);
    cas_n = 1'b0; step(1); cas_n = 1'b1; step(1);
    check("R12 short cas viol", int'(viol), 1);
    ras_close();

    // R11: row strobe held too long
    do_reset();
    ras_n = 1'b0; step(RAS_MAX);
    check("R11 not yet", int'(viol), 0);
    step(1);
    check("R11 viol set", int'(viol), 1);
    ras_n = 1'b1; step(3);
    check("R11 sticky", int'(viol), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule